// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block takes an incoming word stream, framed by an end-of-payload marker, and stores each packet into memory buffers described by a linked list of descriptors. Software builds the list in memory and gives the engine two pointers. The head pointer is where walking begins. The tail pointer is the last descriptor software has handed over. A start strobe launches the walk. The engine reaches memory through one word-wide read/write port with a request/acknowledge handshake.

Each descriptor is eight 32-bit words, at byte offsets 0, 4, 8, 12, 16, 20, 24 and 28:

| Offset | Content |
|---|---|
| 0 | Link to the next descriptor |
| 4 | Buffer base address |
| 8 | Free space in the buffer, in bytes |
| 12 | Status/control word |
| 16 to 28 | Four application words |

The engine fills the buffers in order. When one buffer runs out of room, the packet spills into the next buffer. When a packet ends, the five footer words that follow the marker go into the descriptor holding the packet end. The engine then marks each finished descriptor in memory. It raises a sticky interrupt when a finished descriptor asks for one.

Top module: `rxd_rx_chain_dma`

## Requirements
- R1: After reset, `irq`, `s_ready` and `mem_req` are low, and they stay low until `ctl_start` is pulsed.
- R2: A pulse on `ctl_start` while idle or parked starts a walk at `ctl_head_ptr`. The engine reads exactly four words of each descriptor: byte offsets 0, 4, 8 and 12.
- R3: Payload words go to consecutive word addresses starting at the buffer address. A buffer holds floor(length/4) words, and only the low `LEN_W` bits of the length word count.
- R4: When a buffer becomes full before the end marker, the engine finishes that descriptor without the end flag. It then follows the link word and writes the rest of the packet into the next buffer.
- R5: Status write-back applies to every finished descriptor. Bit 3 (done) is set. Bit 4 (first) is set in the descriptor that got the packet's first word. Bit 5 (last) is set in the descriptor that got its last word. The other bits 0 to 7 keep their fetched values. The status word is the last word written for a descriptor.
- R6: The five words after the end marker are the footer. Bits 31:8 of footer word 0 replace status bits 31:8, and footer words 1 to 4 go to byte offsets 16, 20, 24 and 28. A descriptor finished without the end flag keeps its status bits 31:8.
- R7: A descriptor with zero word capacity gets bits 0 (error) and 3 set. It receives no data and is passed over.
- R8: After the descriptor at `ctl_tail_ptr` is finished, `s_ready` stays low and nothing is written, so input is stalled and not dropped. Once `ctl_tail_ptr` differs from that descriptor's address, the engine resumes at its link word.
- R9: Finishing a descriptor whose bit 1 is set drives `irq` high. It stays high until a one-cycle `irq_clr` strobe, and a set in the same cycle wins over the clear.
- R10: Every packet begins at the start of a fresh buffer, even when the previous buffer has room left.
- R11: A memory request holds its address until `mem_ack`, and a payload word is taken from the stream only in the cycle its write is acknowledged. Every target word is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_start | input | 1 | Start strobe, loads the head pointer |
| ctl_head_ptr | input | ADDR_W | Byte address of the first descriptor |
| ctl_tail_ptr | input | ADDR_W | Byte address of the last descriptor handed over |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| irq | output | 1 | Sticky interrupt |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Marks the last payload word of a packet |
| s_ready | output | 1 | Stream word accepted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |

## Verification
The bench builds the engine with `ADDR_W` = 12 and `LEN_W` = 8. This keeps the whole descriptor and buffer space inside a 4 KiB model memory and makes byte lengths such as 30 and 2 meaningful: one rounds down to seven words and the other gives zero capacity. A randomly withheld acknowledge stretches both descriptor reads and payload writes. The chosen chain covers a packet that fits, a packet that spills across two buffers, an exact fill, a zero-capacity descriptor and a stall at the tail pointer followed by resumption.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // Descriptor geometry: eight words, the first four are fetched
  localparam int DESC_WORDS = 8;
  localparam int FOOT_WORDS = 5;

  // Status word bit positions decoded by software
  localparam int BIT_ERR    = 0;
  localparam int BIT_IRQ_EN = 1;
  localparam int BIT_DONE   = 3;
  localparam int BIT_SOP    = 4;
  localparam int BIT_EOP    = 5;
  localparam int FOOT_LSB   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FILL,
    ST_FOOT,
    ST_WBACK,
    ST_PARK
  } rxd_state_e;

endpackage

// File: rtl/rxd_desc_regs.sv
module rxd_desc_regs #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_idx,
  input  logic [31:0]       ld_data,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] buf_ptr,
  output logic [LEN_W-3:0]  buf_words,
  output logic [31:0]       stat_ctl
);

  logic [ADDR_W-1:0] next_q, buf_q;
  logic [LEN_W-3:0]  words_q;
  logic [31:0]       stat_q;
  logic              en_next, en_buf, en_len, en_stat;

  assign en_next = ld_en && (ld_idx == 2'd0);
  assign en_buf  = ld_en && (ld_idx == 2'd1);
  assign en_len  = ld_en && (ld_idx == 2'd2);
  assign en_stat = ld_en && (ld_idx == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q  <= '0;
      buf_q   <= '0;
      words_q <= '0;
      stat_q  <= '0;
    end else begin
      if (en_next) next_q  <= ld_data[ADDR_W-1:0];
      if (en_buf)  buf_q   <= ld_data[ADDR_W-1:0];
      if (en_len)  words_q <= ld_data[LEN_W-1:2];
      if (en_stat) stat_q  <= ld_data;
    end
  end

  assign next_ptr  = next_q;
  assign buf_ptr   = buf_q;
  assign buf_words = words_q;
  assign stat_ctl  = stat_q;

endmodule

// File: rtl/rxd_footer_buf.sv
module rxd_footer_buf #(
  parameter int WORDS = 5,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [31:0]           wr_data,
  output logic [WORDS-1:0][31:0] words
);

  logic [WORDS-1:0][31:0] word_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (slot_en) begin
        word_q[g] <= wr_data;
      end
    end
  end

  assign words = word_q;

endmodule

// File: rtl/rxd_status_build.sv
module rxd_status_build import rxd_pkg::*; (
  input  logic [31:0] old_word,
  input  logic [31:0] foot0,
  input  logic        mark_sop,
  input  logic        mark_eop,
  input  logic        mark_err,
  output logic [31:0] new_word
);

  logic [FOOT_LSB-1:0] foot_lo_unused;
  assign foot_lo_unused = foot0[FOOT_LSB-1:0];

  always_comb begin
    new_word           = old_word;
    new_word[BIT_DONE] = 1'b1;
    if (mark_sop) new_word[BIT_SOP] = 1'b1;
    if (mark_err) new_word[BIT_ERR] = 1'b1;
    if (mark_eop) begin
      new_word[BIT_EOP]     = 1'b1;
      new_word[31:FOOT_LSB] = foot0[31:FOOT_LSB];
    end
  end

endmodule

// File: rtl/rxd_irq_ctl.sv
module rxd_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_pulse,
  output logic irq
);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr_pulse) irq_d = 1'b0;
    if (set_pulse) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_pulse) |=> irq_q);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !set_pulse) |=> !irq_q);

endmodule

// File: rtl/rxd_rx_chain_dma.sv
module rxd_rx_chain_dma import rxd_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_start,
  input  logic [ADDR_W-1:0] ctl_head_ptr,
  input  logic [ADDR_W-1:0] ctl_tail_ptr,
  input  logic              irq_clr,
  output logic              irq,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  localparam int SPC_W = LEN_W - 2;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_STAT  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_APP0  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DESC_WORDS - 1);
  localparam logic [IDX_W-1:0] FOOT_END  = IDX_W'(FOOT_WORDS - 1);

  rxd_state_e        state_q, state_d;
  logic [ADDR_W-1:0] desc_q, desc_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [SPC_W-1:0]  space_q, space_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [IDX_W-1:0]  fcnt_q, fcnt_d;
  logic              in_pkt_q, in_pkt_d;
  logic              sop_q, sop_d;
  logic              eop_q, eop_d;
  logic              err_q, err_d;

  logic              ld_en, foot_we, irq_set, fill_xfer;
  logic [ADDR_W-1:0] d_next, d_buf, word_addr;
  logic [SPC_W-1:0]  d_words;
  logic [31:0]       d_stat, stat_word;
  logic [FOOT_WORDS-1:0][31:0] foot_w;
  logic [IDX_W-1:0]  fsel;

  rxd_desc_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_idx    (widx_q[1:0]),
    .ld_data   (mem_rdata),
    .next_ptr  (d_next),
    .buf_ptr   (d_buf),
    .buf_words (d_words),
    .stat_ctl  (d_stat)
  );

  rxd_footer_buf #(.WORDS(FOOT_WORDS), .IDX_W(IDX_W)) u_foot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (foot_we),
    .wr_idx  (fcnt_q),
    .wr_data (s_data),
    .words   (foot_w)
  );

  rxd_status_build u_stat (
    .old_word (d_stat),
    .foot0    (foot_w[0]),
    .mark_sop (sop_q),
    .mark_eop (eop_q),
    .mark_err (err_q),
    .new_word (stat_word)
  );

  rxd_irq_ctl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (irq_set),
    .clr_pulse (irq_clr),
    .irq       (irq)
  );

  assign word_addr = desc_q + {{(ADDR_W-IDX_W-2){1'b0}}, widx_q, 2'b00};
  assign fsel      = widx_q - IDX_STAT;
  assign fill_xfer = (state_q == ST_FILL) && s_valid && mem_ack;

  // Memory and stream port drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = word_addr;
    mem_wdata = '0;
    s_ready   = 1'b0;
    unique case (state_q)
      ST_FETCH: mem_req = 1'b1;
      ST_FILL: begin
        mem_req   = s_valid;
        mem_we    = 1'b1;
        mem_addr  = wptr_q;
        mem_wdata = s_data;
        s_ready   = mem_ack;
      end
      ST_FOOT: s_ready = 1'b1;
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = (widx_q == IDX_STAT) ? stat_word : foot_w[fsel];
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    desc_d   = desc_q;
    wptr_d   = wptr_q;
    space_d  = space_q;
    widx_d   = widx_q;
    fcnt_d   = fcnt_q;
    in_pkt_d = in_pkt_q;
    sop_d    = sop_q;
    eop_d    = eop_q;
    err_d    = err_q;
    ld_en    = 1'b0;
    foot_we  = 1'b0;
    irq_set  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PARK: begin
        if (ctl_start) begin
          desc_d  = ctl_head_ptr;
          widx_d  = '0;
          state_d = ST_FETCH;
        end else if (state_q == ST_PARK && ctl_tail_ptr != desc_q) begin
          desc_d  = d_next;
          widx_d  = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          ld_en = 1'b1;
          if (widx_q == IDX_STAT) begin
            wptr_d  = d_buf;
            space_d = d_words;
            sop_d   = 1'b0;
            eop_d   = 1'b0;
            err_d   = (d_words == '0);
            state_d = (d_words == '0) ? ST_WBACK : ST_FILL;
          end else begin
            widx_d = widx_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (fill_xfer) begin
          wptr_d  = wptr_q + ADDR_W'(4);
          space_d = space_q - 1'b1;
          if (!in_pkt_q) sop_d = 1'b1;
          if (s_last) begin
            eop_d    = 1'b1;
            in_pkt_d = 1'b0;
            fcnt_d   = '0;
            state_d  = ST_FOOT;
          end else begin
            in_pkt_d = 1'b1;
            if (space_q == SPC_W'(1)) begin
              widx_d  = IDX_STAT;
              state_d = ST_WBACK;
            end
          end
        end
      end
      ST_FOOT: begin
        if (s_valid) begin
          foot_we = 1'b1;
          fcnt_d  = fcnt_q + 1'b1;
          if (fcnt_q == FOOT_END) begin
            widx_d  = IDX_APP0;
            state_d = ST_WBACK;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          if (widx_q == IDX_LAST) begin
            widx_d = IDX_STAT;
          end else if (widx_q == IDX_STAT) begin
            irq_set = d_stat[BIT_IRQ_EN];
            widx_d  = '0;
            if (desc_q == ctl_tail_ptr) begin
              state_d = ST_PARK;
            end else begin
              desc_d  = d_next;
              state_d = ST_FETCH;
            end
          end else begin
            widx_d = widx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      desc_q   <= '0;
      wptr_q   <= '0;
      space_q  <= '0;
      widx_q   <= '0;
      fcnt_q   <= '0;
      in_pkt_q <= 1'b0;
      sop_q    <= 1'b0;
      eop_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      desc_q   <= desc_d;
      wptr_q   <= wptr_d;
      space_q  <= space_d;
      widx_q   <= widx_d;
      fcnt_q   <= fcnt_d;
      in_pkt_q <= in_pkt_d;
      sop_q    <= sop_d;
      eop_q    <= eop_d;
      err_q    <= err_d;
    end
  end

  // R8
  park_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK || state_q == ST_IDLE) |-> !s_ready);

  // R4
  fill_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> (space_q != '0));

  // R6
  foot_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FOOT) |-> (fcnt_q < IDX_W'(FOOT_WORDS)));

  // R5
  stat_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK && mem_ack && widx_q == IDX_STAT) |=> (state_q != ST_WBACK));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && state_q != ST_FILL) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/rxd_rx_chain_dma_bench.sv
module rxd_rx_chain_dma_bench;

  localparam int AW = 12;
  localparam int LW = 8;
  localparam int DB = 0;
  localparam int BB = 256;

  logic          clk, rst_n;
  logic          ctl_start, irq_clr, irq;
  logic [AW-1:0] ctl_head_ptr, ctl_tail_ptr;
  logic          s_valid, s_last, s_ready;
  logic [31:0]   s_data;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_mem [int];
  string       exp_tag [int];
  bit          written [int];
  logic [32:0] sq [$];
  logic [7:0]  lfsr;
  bit          s_en;
  int          nchk, nerr, nwr, md;
  int          dlen [8];
  logic [31:0] dctl [8];

  rxd_rx_chain_dma #(.ADDR_W(AW), .LEN_W(LW)) u_rxd_rx_chain_dma (
    .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_head_ptr(ctl_head_ptr),
    .ctl_tail_ptr(ctl_tail_ptr), .irq_clr(irq_clr), .irq(irq),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[AW-1:2]];
  assign mem_ack   = lfsr[0] | lfsr[2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic put_exp(input int a, input logic [31:0] v, input string tag);
    exp_mem[a] = v;
    exp_tag[a] = tag;
  endtask

  // Behavioural model: walks the posted chain for one packet and queues the stream
  task automatic model_pkt(input int n, input int seed);
    int rem, w;
    bit first;
    logic [31:0] st, f [5];
    rem = n; w = 0; first = 1'b1;
    for (int i = 0; i < 5; i++) f[i] = 32'hF000_0000 | (seed << 8) | i;
    for (int i = 0; i < n; i++) sq.push_back({(i == n - 1), 16'(seed), 16'(i)});
    for (int i = 0; i < 5; i++) sq.push_back({1'b0, f[i]});
    while (rem > 0) begin
      int da, cap, k;
      da  = DB + 32 * md;
      cap = dlen[md] / 4;
      if (cap == 0) begin
        put_exp(da + 12, dctl[md] | 32'h9, "R7");
        md++;
        continue;
      end
      k = (cap < rem) ? cap : rem;
      for (int j = 0; j < k; j++) begin
        put_exp(BB + 64 * md + 4 * j, {16'(seed), 16'(w)},
                (j == 0 && first) ? "R10" : (first ? "R3" : "R4"));
        w++;
      end
      rem -= k;
      st = dctl[md] | 32'h8 | (first ? 32'h10 : 32'h0);
      if (rem == 0) begin
        st = {f[0][31:8], st[7:0]} | 32'h20;
        for (int j = 1; j < 5; j++) put_exp(da + 12 + 4 * j, f[j], "R6");
      end
      put_exp(da + 12, st, (rem == 0) ? "R6" : "R5");
      first = 1'b0;
      md++;
    end
  endtask

  task automatic check_all_written();
    foreach (exp_mem[a])
      chk(written.exists(a), exp_tag[a], $sformatf("missing write at %0h", a), 32'(a), exp_mem[a]);
  endtask

  // Input drive, away from the active edge
  always @(posedge clk) begin
    #1;
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    s_valid <= s_en && (sq.size() > 0);
    {s_last, s_data} <= (sq.size() > 0) ? sq[0] : 33'h0;
  end

  // Memory model and per-cycle comparison against the expected image
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_valid && s_ready) void'(sq.pop_front());
      if (mem_req && !mem_we && mem_ack)
        chk((int'(mem_addr) < BB) && (mem_addr[4:0] <= 5'd12), "R2",
            "descriptor read address", 32'(mem_addr), 32'h0);
      if (mem_req && mem_we && mem_ack) begin
        int a;
        a = int'(mem_addr);
        nwr++;
        if (exp_mem.exists(a))
          chk(mem_wdata == exp_mem[a], exp_tag[a], $sformatf("write at %0h", a), mem_wdata, exp_mem[a]);
        else
          chk(1'b0, "R8", $sformatf("unexpected write at %0h", a), mem_wdata, 32'h0);
        written[a] = 1'b1;
        mem[mem_addr[AW-1:2]] = mem_wdata;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R8: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0; nwr = 0; md = 0; s_en = 1'b0;
    lfsr = 8'h5B;
    rst_n = 1'b0; ctl_start = 1'b0; irq_clr = 1'b0;
    ctl_head_ptr = '0; ctl_tail_ptr = '0;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    dlen = '{64, 30, 64, 2, 16, 64, 64, 64};
    for (int i = 0; i < 8; i++) begin
      dctl[i] = 32'h5A5A_5A00;
      if (i == 0 || i == 5) dctl[i] |= 32'h2;
      if (i == 2) dctl[i] |= 32'h40;
      mem[(DB + 32 * i) / 4 + 0] = DB + 32 * (i + 1);
      mem[(DB + 32 * i) / 4 + 1] = BB + 64 * i;
      mem[(DB + 32 * i) / 4 + 2] = dlen[i];
      mem[(DB + 32 * i) / 4 + 3] = dctl[i];
      for (int j = 4; j < 8; j++) mem[(DB + 32 * i) / 4 + j] = 32'hA000 + 16 * i + j;
    end

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'h0);
    chk(s_ready == 1'b0, "R1", "s_ready before start", 32'(s_ready), 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req before start", 32'(mem_req), 32'h0);

    // Phase 1: fit, spill, zero-capacity and exact fill, parking at d4
    model_pkt(3, 1);
    model_pkt(20, 2);
    model_pkt(4, 3);
    ctl_head_ptr = AW'(DB);
    ctl_tail_ptr = AW'(DB + 32 * 4);
    @(posedge clk); #1 ctl_start = 1'b1;
    @(posedge clk); #1 ctl_start = 1'b0;
    s_en = 1'b1;
    while (sq.size() != 0) @(posedge clk);
    repeat (60) @(posedge clk);
    check_all_written();
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq after flagged descriptor", 32'(irq), 32'h1);

    // Phase 2: stall at tail, sticky irq, clear, then resume
    model_pkt(5, 4);
    repeat (30) begin
      @(negedge clk);
      chk(s_ready == 1'b0, "R8", "s_ready while parked", 32'(s_ready), 32'h0);
    end
    chk(sq.size() == 10, "R8", "words held while parked", 32'(sq.size()), 32'd10);
    chk(irq == 1'b1, "R9", "irq held without clear", 32'(irq), 32'h1);
    @(posedge clk); #1 irq_clr = 1'b1;
    @(posedge clk); #1 irq_clr = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R9", "irq after clear strobe", 32'(irq), 32'h0);
    @(posedge clk); #1 ctl_tail_ptr = AW'(DB + 32 * 6);
    while (sq.size() != 0) @(posedge clk);
    repeat (60) @(posedge clk);
    check_all_written();
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq after resumed descriptor", 32'(irq), 32'h1);
    chk(nwr == exp_mem.size(), "R11", "total acknowledged writes", 32'(nwr), 32'(exp_mem.size()));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule